// File: doc/BRIEF.md
# Doorbell Message Handshake Engine

This block is the device side of a 32-bit doorbell register on a small register bus. A host starts an exchange by writing a function word to the doorbell. The word carries the handshake code and a request length in dwords. The host then writes that many request dwords. Once the last dword is in, the engine hands a reply back one 16-bit halfword at a time in the low half of the doorbell read data.

A write-1-to-clear status bit gates each halfword. The engine raises the bit when a halfword is ready, and the host clears it to ask for the next one. The reply echoes the captured request: each stored dword is returned low half first, then high half, so the reply is twice the request length in halfwords. Dwords beyond the local buffer depth are accepted and counted, and their reply halfwords read as zero.

When no exchange is running, the upper byte of the doorbell shows the controller state, a busy flag and an initiator identifier. Reset function codes written outside request capture abort an exchange and return the state to ready.

Top module: `dbell_hs_engine`

## Requirements
- R1: After reset, a doorbell read (offset 0x00) returns 0x1000_0000: state field bits 31:28 = 1 (ready), in-use bit 27 = 0, initiator bits 26:24 = 0, low half 0. A status read (offset 0x30) returns 0.
- R2: A doorbell write with bits 31:24 = 0x42 and a nonzero length N in bits 23:16 sets the in-use bit 27, and the next N doorbell writes are captured as request dwords.
- R3: One clock after the edge that captures the last request dword, status bit 0 reads 1 and the doorbell low half shows reply halfword 0. Reply halfword 2k is request dword k bits 15:0 and halfword 2k+1 is bits 31:16; the reply holds 2N halfwords.
- R4: A status write with bit 0 = 1 while the bit is set clears it at that edge, and the next halfword appears with the bit set one clock later. A status write with bit 0 = 0 changes nothing.
- R5: While status bit 0 is clear, the doorbell low half keeps the last presented halfword.
- R6: The in-use bit stays 1 until the last reply halfword is acknowledged. It then drops to 0 and the state field becomes 2 (operational).
- R7: With the default depth of 8, request dwords past the eighth are consumed, and their reply halfwords read 0x0000.
- R8: During the reply phase, a new 0x42 function word with nonzero length aborts the reply, clears status bit 0 and restarts capture. If it lands in the cycle that would present the next halfword, the restart wins.
- R9: Outside capture, codes 0x40 and 0x41 end any exchange, clear in-use and status bit 0, and set the state field to 1. Code 0x43 and other codes leave the engine unchanged.
- R10: During capture, every doorbell write is data, including words whose top byte is 0x40 to 0x43.
- R11: A 0x42 function word with length 0 is ignored; in-use stays 0.
- R12: Reads of other offsets return 0, and writes to other offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational, no side effect) |

## Verification
Two of the block's actions can fall on one clock edge: presenting the next reply halfword, which happens on the edge after an acknowledge, and a restart function word. The bench acknowledges a halfword and then writes a new 0x42 word in the very next cycle, so both land on the edge where presentation would occur. It judges the outcome at the ports: the status bit must stay clear, in-use must stay set while capture runs, and the next reply must echo the new request rather than the old one.

// File: rtl/dbell_hs_pkg.sv
package dbell_hs_pkg;

  localparam logic [7:0] FN_MSG_RESET  = 8'h40;
  localparam logic [7:0] FN_UNIT_RESET = 8'h41;
  localparam logic [7:0] FN_HANDSHAKE  = 8'h42;
  localparam logic [7:0] FN_FRAME_DROP = 8'h43;

  localparam logic [7:0] OFS_DOORBELL  = 8'h00;
  localparam logic [7:0] OFS_STATUS    = 8'h30;

  localparam logic [3:0] CST_READY     = 4'h1;
  localparam logic [3:0] CST_OPER      = 4'h2;

  typedef enum logic [1:0] {PH_IDLE, PH_COLLECT, PH_ANSWER} phase_e;

  // number of reply halfwords for a request of n dwords
  function automatic logic [8:0] reply_halves(input logic [7:0] n);
    return {n, 1'b0};
  endfunction

  // halfword select within a dword: 0 = low half first
  function automatic logic [15:0] half_of(input logic [31:0] dw, input logic upper);
    return upper ? dw[31:16] : dw[15:0];
  endfunction

endpackage

// File: rtl/dbell_req_store.sv
module dbell_req_store #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  len_i,
  input  logic        take_i,
  input  logic [31:0] data_i,
  input  logic [7:0]  rd_idx_i,
  output logic        last_o,
  output logic [31:0] rd_data_o
);
  localparam int         AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [7:0] DEPTH_B = 8'(DEPTH);

  logic [7:0]  cnt_q, len_q;
  logic [31:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      len_q <= len_i;
    end else if (take_i) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[g] <= '0;
      else if (take_i && cnt_q == 8'(g)) slot[g] <= data_i;
    end
  end

  assign last_o    = take_i && (cnt_q + 8'd1 == len_q);
  assign rd_data_o = (rd_idx_i < DEPTH_B) ? slot[rd_idx_i[AW-1:0]] : 32'h0;

endmodule

// File: rtl/dbell_reply_seq.sv
module dbell_reply_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        begin_i,
  input  logic        abort_i,
  input  logic        ack_i,
  input  logic [8:0]  total_i,
  input  logic [15:0] hw_i,
  output logic [8:0]  ptr_o,
  output logic        flag_o,
  output logic [15:0] hw_o,
  output logic        present_o,
  output logic        ack_evt_o,
  output logic        done_o
);
  logic [8:0]  ptr_q;
  logic        flag_q, armed_q;
  logic [15:0] hw_q;

  assign present_o = armed_q && !flag_q && !abort_i && !begin_i;
  assign ack_evt_o = ack_i && flag_q && !abort_i && !begin_i;
  assign done_o    = ack_evt_o && (ptr_q + 9'd1 == total_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      hw_q    <= '0;
    end else if (abort_i) begin
      ptr_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (begin_i) begin
      ptr_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (present_o) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
      hw_q    <= hw_i;
    end else if (ack_evt_o) begin
      flag_q <= 1'b0;
      if (done_o) begin
        armed_q <= 1'b0;
      end else begin
        ptr_q   <= ptr_q + 9'd1;
        armed_q <= 1'b1;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign flag_o = flag_q;
  assign hw_o   = hw_q;

endmodule

// File: rtl/dbell_hs_engine.sv
module dbell_hs_engine
  import dbell_hs_pkg::*;
#(
  parameter int         DEPTH  = 8,
  parameter logic [2:0] WHO_ID = 3'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  phase_e      phase_q;
  logic [3:0]  cstate_q;
  logic [8:0]  total_q;

  logic [7:0]  fn_code, req_len;
  logic        db_wr, ack_cmd, hs_start, unit_rst, take, abort;
  logic        in_use, collecting, cap_last;
  logic        sys_flag, present_evt, ack_evt, done_evt;
  logic [8:0]  ptr;
  logic [15:0] hw_q, hw_next;
  logic [31:0] store_dw;

  assign fn_code    = bus_wdata[31:24];
  assign req_len    = bus_wdata[23:16];
  assign db_wr      = bus_wr && (bus_addr == OFS_DOORBELL);
  assign ack_cmd    = bus_wr && (bus_addr == OFS_STATUS) && bus_wdata[0];
  assign collecting = (phase_q == PH_COLLECT);
  assign in_use     = (phase_q != PH_IDLE);
  assign hs_start   = db_wr && !collecting && (fn_code == FN_HANDSHAKE) && (req_len != 8'd0);
  assign unit_rst   = db_wr && !collecting &&
                      ((fn_code == FN_MSG_RESET) || (fn_code == FN_UNIT_RESET));
  assign take       = db_wr && collecting;
  assign abort      = (phase_q == PH_ANSWER) && (hs_start || unit_rst);

  dbell_req_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (hs_start),
    .len_i     (req_len),
    .take_i    (take),
    .data_i    (bus_wdata),
    .rd_idx_i  (ptr[8:1]),
    .last_o    (cap_last),
    .rd_data_o (store_dw)
  );

  assign hw_next = half_of(store_dw, ptr[0]);

  dbell_reply_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .begin_i   (cap_last),
    .abort_i   (abort),
    .ack_i     (ack_cmd),
    .total_i   (total_q),
    .hw_i      (hw_next),
    .ptr_o     (ptr),
    .flag_o    (sys_flag),
    .hw_o      (hw_q),
    .present_o (present_evt),
    .ack_evt_o (ack_evt),
    .done_o    (done_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cstate_q <= CST_READY;
      total_q  <= '0;
    end else begin
      if (hs_start) begin
        phase_q <= PH_COLLECT;
        total_q <= reply_halves(req_len);
      end else if (unit_rst) begin
        phase_q  <= PH_IDLE;
        cstate_q <= CST_READY;
      end else if (cap_last) begin
        phase_q <= PH_ANSWER;
      end else if (done_evt) begin
        phase_q  <= PH_IDLE;
        cstate_q <= CST_OPER;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_DOORBELL: bus_rdata = {cstate_q, in_use, WHO_ID, 8'h00, hw_q};
      OFS_STATUS:   bus_rdata = {31'h0, sys_flag};
      default:      bus_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/dbell_hs_chk.sv
module dbell_hs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        db_wr,
  input logic [7:0]  fn_code,
  input logic [7:0]  req_len,
  input logic        ack_cmd,
  input logic        hs_start,
  input logic        abort,
  input logic        unit_rst,
  input logic        in_use,
  input logic        collecting,
  input logic        sys_flag,
  input logic        present_evt,
  input logic        done_evt,
  input logic [15:0] hw_q
);
  // R2
  in_use_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_use) |-> $past(db_wr && fn_code == 8'h42));

  // R3
  flag_in_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_flag) |-> (in_use && !collecting));

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_flag && ack_cmd) |=> !sys_flag);

  // R5
  hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_flag && !present_evt) |=> $stable(hw_q));

  // R6
  in_use_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_use) |-> $past(done_evt || unit_rst));

  // R8
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && hs_start) |=> (collecting && !sys_flag));

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_use && db_wr && fn_code == 8'h42 && req_len == 8'd0) |=> !in_use);

endmodule

bind dbell_hs_engine dbell_hs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .db_wr       (db_wr),
  .fn_code     (fn_code),
  .req_len     (req_len),
  .ack_cmd     (ack_cmd),
  .hs_start    (hs_start),
  .abort       (abort),
  .unit_rst    (unit_rst),
  .in_use      (in_use),
  .collecting  (collecting),
  .sys_flag    (sys_flag),
  .present_evt (present_evt),
  .done_evt    (done_evt),
  .hw_q        (hw_q)
);

// File: tb/dbell_hs_engine_tb.sv
module dbell_hs_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  dbell_hs_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // table: {request length, seed}
  localparam int NVEC = 4;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd1,  32'hA5A5_0001},
    {8'd3,  32'h1234_5678},
    {8'd8,  32'h0F0F_7700},
    {8'd10, 32'hC001_0203}
  };

  function automatic logic [31:0] gen_dw(input logic [31:0] seed, input int k);
    return seed + 32'(k) * 32'h0103_0507;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  // wait for the status bit, compare the halfword, acknowledge it
  task automatic take_half(input logic [15:0] exp, input string req);
    logic [31:0] v;
    int tries = 0;
    rd(8'h30, v);
    while (v[0] !== 1'b1 && tries < 20) begin
      step(); tries++; rd(8'h30, v);
    end
    if (v[0] !== 1'b1) check({req, " flag"}, v, 32'h1);
    rd(8'h00, v);
    check(req, {16'h0, v[15:0]}, {16'h0, exp});
    wr(8'h30, 32'h1);
  endtask

  task automatic run_all;
    logic [31:0] v;
    // R1 reset values
    rd(8'h00, v); check("R1 doorbell", v, 32'h1000_0000);
    rd(8'h30, v); check("R1 status", v, 32'h0);

    // R12 other offsets
    rd(8'h10, v); check("R12 read", v, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R12 write", v, 32'h1000_0000);

    // R11 zero length ignored
    wr(8'h00, 32'h4200_0000);
    rd(8'h00, v); check("R11 in-use", {31'h0, v[27]}, 32'h0);

    // table walk: R2 R3 R6 R7
    for (int c = 0; c < NVEC; c++) begin
      logic [7:0]  n;
      logic [31:0] seed;
      n = VEC[c][39:32]; seed = VEC[c][31:0];
      wr(8'h00, {8'h42, n, 16'h0});
      rd(8'h00, v); check("R2 in-use", {31'h0, v[27]}, 32'h1);
      for (int k = 0; k < int'(n); k++) wr(8'h00, gen_dw(seed, k));
      for (int i = 0; i < 2 * int'(n); i++) begin
        logic [15:0] e;
        logic [31:0] d;
        d = gen_dw(seed, i / 2);
        e = (i / 2 >= 8) ? 16'h0 : ((i % 2) ? d[31:16] : d[15:0]);
        if (i == 2 * int'(n) - 1) begin
          rd(8'h00, v); check("R6 busy before last", {31'h0, v[27]}, 32'h1);
        end
        take_half(e, (i / 2 >= 8) ? "R7 beyond depth" : "R3 echo");
      end
      rd(8'h00, v); check("R6 idle state", {24'h0, v[31:24]}, 32'h20);
    end

    // R3 R4 R5 exact timing
    wr(8'h00, 32'h4202_0000);
    wr(8'h00, 32'h1111_2222);
    wr(8'h00, 32'h3333_4444);
    rd(8'h30, v); check("R3 flag not yet", v, 32'h0);
    step();
    rd(8'h30, v); check("R3 flag set", v, 32'h1);
    rd(8'h00, v); check("R3 first half", {16'h0, v[15:0]}, 32'h2222);
    wr(8'h30, 32'h0);
    rd(8'h30, v); check("R4 write zero", v, 32'h1);
    wr(8'h30, 32'h1);
    rd(8'h30, v); check("R4 cleared", v, 32'h0);
    rd(8'h00, v); check("R5 held", {16'h0, v[15:0]}, 32'h2222);
    step();
    rd(8'h30, v); check("R4 next flag", v, 32'h1);
    rd(8'h00, v); check("R4 next half", {16'h0, v[15:0]}, 32'h1111);

    // R8 restart on the presentation edge
    wr(8'h30, 32'h1);
    wr(8'h00, 32'h4201_0000);
    rd(8'h30, v); check("R8 flag held clear", v, 32'h0);
    rd(8'h00, v); check("R8 in-use", {31'h0, v[27]}, 32'h1);
    step();
    rd(8'h30, v); check("R8 collecting", v, 32'h0);
    wr(8'h00, 32'hBEEF_CAFE);
    take_half(16'hCAFE, "R8 new low");
    take_half(16'hBEEF, "R8 new high");
    rd(8'h00, v); check("R8 done", {24'h0, v[31:24]}, 32'h20);

    // R10 reset codes inside capture are data
    wr(8'h00, 32'h4202_0000);
    wr(8'h00, 32'h4100_5555);
    wr(8'h00, 32'h4300_6666);
    take_half(16'h5555, "R10 d0 low");
    take_half(16'h4100, "R10 d0 high");
    take_half(16'h6666, "R10 d1 low");
    take_half(16'h4300, "R10 d1 high");

    // R9 frame-drop ignored, unit reset aborts
    wr(8'h00, 32'h4201_0000);
    wr(8'h00, 32'h0000_7777);
    step();
    wr(8'h00, 32'h4300_0000);
    rd(8'h30, v); check("R9 ignored flag", v, 32'h1);
    rd(8'h00, v); check("R9 ignored word", {v[31:24], 8'h0, v[15:0]}, 32'h2800_7777);
    wr(8'h00, 32'h4100_0000);
    rd(8'h30, v); check("R9 flag cleared", v, 32'h0);
    rd(8'h00, v); check("R9 ready idle", {24'h0, v[31:24]}, 32'h10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule